// File: doc/BRIEF.md
# Add-Immediate Execute Unit with Carry Control

This block is the execute slice for a family of four add-immediate instructions in a 32-bit RISC datapath. Each cycle it may receive a valid instruction word, together with the value of the source register and the current machine-status carry flag. It decodes the word and adds the source value to an immediate operand. One cycle later it presents the destination register index, the sum with a write enable, and the next value of the carry flag.

Two opcode bits control the carry independently. One bit adds the incoming carry flag as a carry-in. The other bit keeps the flag at its old value instead of loading the carry-out. A separate prefix instruction supplies the upper half of the immediate. While a prefix is pending, the next instruction uses a full 32-bit immediate instead of the sign-extended 16-bit field. The block also presents the source register index as a combinational output, so that a register file can supply `src_val` in the same cycle.

Top module: `addimm_exec`

## Requirements
- R1: Bit positions count from 0 at the most significant end. The fields are: opcode in bits 0–5 (word[31:26]), destination index in bits 6–10 (word[25:21]), source index in bits 11–15 (word[20:16]) and the immediate in bits 16–31 (word[15:0]). A valid word whose opcode matches 0,0,1,K,C,0 is an add. On the next clock edge it raises `wr_en` for exactly one cycle, with `wr_idx` set to its destination field.
- R2: With no prefix pending, the operand is the 16-bit immediate sign-extended to 32 bits, and `wr_data` is the 32-bit sum.
- R3: Opcode bit 4 (word[27]) set adds `carry_in` as a carry-in. When it is clear, no carry-in is added, whatever the value of `carry_in`.
- R4: With opcode bit 3 (word[28]) clear, `carry_next` is loaded with bit 32 of the 33-bit sum.
- R5: With opcode bit 3 set, `carry_next` takes the value of `carry_in`, whatever the carry-out.
- R6: A valid word with opcode 101100 (word[31:26]) is a prefix. It latches word[15:0] as the upper half of the next immediate, does not write, and sets `carry_next` to `carry_in`. The next add uses {upper, word[15:0]} as its operand.
- R7: The pending prefix is cleared by the next valid instruction of any kind. Cycles without `ins_valid` leave it pending.
- R8: A valid word that matches neither the add pattern nor the prefix opcode produces no write and sets `carry_next` to `carry_in`.
- R9: In a cycle without `ins_valid`, `wr_en` is low on the next cycle and `carry_next` holds its value.
- R10: Synchronous active-high reset clears `wr_en`, `carry_next` and any pending prefix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word is valid this cycle |
| ins_word | input | 32 | Instruction word |
| src_val | input | 32 | Value of the source register |
| carry_in | input | 1 | Current machine-status carry flag |
| src_idx | output | 5 | Source register index decoded from the word (combinational) |
| wr_en | output | 1 | Destination write enable (registered) |
| wr_idx | output | 5 | Destination register index (registered) |
| wr_data | output | 32 | Sum to write (registered) |
| carry_next | output | 1 | Next carry flag value (registered) |

## Verification
The hardest situations to reach are those that depend on the prefix state. These include a prefix followed by a non-add word or by idle cycles before the add, and a reset that lands while a prefix is pending. Random opcodes seldom line up that way, so directed sequences build each of these orderings explicitly. Random traffic, weighted toward prefix and add opcodes, then covers the remaining combinations. The carry corner cases are also directed: a carry-in that is the only source of overflow, and a keep-carry add that overflows while the incoming flag is clear.

// File: rtl/addimm_pkg.sv
package addimm_pkg;
  localparam int OPC_W = 6;
  // opcode bits, counted from the word's top
  localparam logic [2:0] ADD_HEAD = 3'b001;
  localparam logic       ADD_TAIL = 1'b0;
  localparam logic [OPC_W-1:0] PFX_OPC = 6'b101100;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_ADD  = 2'd1,
    KIND_PFX  = 2'd2
  } ins_kind_e;
endpackage

// File: rtl/addimm_decode.sv
module addimm_decode
  import addimm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic [DATA_W-1:0] word,
  output ins_kind_e         kind,
  output logic              keep_c,
  output logic              use_c,
  output logic [IDX_W-1:0]  rd,
  output logic [IDX_W-1:0]  rs,
  output logic [IMM_W-1:0]  imm
);
  localparam int OPC_LSB = DATA_W - OPC_W;
  localparam int RD_LSB  = OPC_LSB - IDX_W;
  localparam int RS_LSB  = RD_LSB - IDX_W;

  logic [OPC_W-1:0] opc;

  always_comb begin
    opc    = word[DATA_W-1:OPC_LSB];
    rd     = word[RD_LSB +: IDX_W];
    rs     = word[RS_LSB +: IDX_W];
    imm    = word[IMM_W-1:0];
    keep_c = opc[2];
    use_c  = opc[1];
    if (opc[5:3] == ADD_HEAD && opc[0] == ADD_TAIL)
      kind = KIND_ADD;
    else if (opc == PFX_OPC)
      kind = KIND_PFX;
    else
      kind = KIND_NONE;
  end
endmodule

// File: rtl/addimm_prefix.sv
module addimm_prefix #(
  parameter int UPR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic             load,
  input  logic [UPR_W-1:0] upper_in,
  output logic             pend,
  output logic [UPR_W-1:0] upper
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend  <= 1'b0;
      upper <= '0;
    end else if (advance) begin
      pend <= load;
      if (load) upper <= upper_in;
    end
  end
endmodule

// File: rtl/addimm_adder.sv
module addimm_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout
);
  assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
endmodule

// File: rtl/addimm_exec.sv
module addimm_exec
  import addimm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [DATA_W-1:0] ins_word,
  input  logic [DATA_W-1:0] src_val,
  input  logic              carry_in,
  output logic [IDX_W-1:0]  src_idx,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic              carry_next
);
  localparam int UPR_W = DATA_W - IMM_W;

  ins_kind_e         kind;
  logic              keep_c, use_c;
  logic [IDX_W-1:0]  rd;
  logic [IMM_W-1:0]  imm;
  logic              pend;
  logic [UPR_W-1:0]  upper;
  logic [DATA_W-1:0] operand, sum;
  logic              cout;

  addimm_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IDX_W(IDX_W)) u_dec (
    .word(ins_word), .kind(kind), .keep_c(keep_c), .use_c(use_c),
    .rd(rd), .rs(src_idx), .imm(imm)
  );

  addimm_prefix #(.UPR_W(UPR_W)) u_pfx (
    .clk(clk), .rst(rst), .advance(ins_valid),
    .load(kind == KIND_PFX), .upper_in(imm[UPR_W-1:0]),
    .pend(pend), .upper(upper)
  );

  // pending prefix replaces the sign-extension bits
  always_comb begin
    if (pend) operand = {upper, imm};
    else      operand = {{UPR_W{imm[IMM_W-1]}}, imm};
  end

  addimm_adder #(.DATA_W(DATA_W)) u_add (
    .a(src_val), .b(operand), .cin(use_c & carry_in),
    .sum(sum), .cout(cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_data    <= '0;
      carry_next <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (ins_valid) begin
        carry_next <= carry_in;
        if (kind == KIND_ADD) begin
          wr_en   <= 1'b1;
          wr_idx  <= rd;
          wr_data <= sum;
          if (!keep_c) carry_next <= cout;
        end
      end
    end
  end
endmodule

// File: rtl/addimm_exec_chk.sv
module addimm_exec_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ins_valid,
  input logic [6+IDX_W-1:0] hdr,
  input logic             carry_in,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             carry_next
);
  logic is_add_w;
  assign is_add_w = (hdr[6+IDX_W-1 -: 3] == 3'b001) && !hdr[IDX_W];

  // R1
  add_writes_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && is_add_w) |=> (wr_en && wr_idx == $past(hdr[IDX_W-1:0])));

  // R5
  keep_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && is_add_w && hdr[IDX_W+2]) |=> (carry_next == $past(carry_in)));

  // R8
  nomatch_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !is_add_w) |=> !wr_en);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ins_valid |=> (!wr_en && $stable(carry_next)));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!wr_en && !carry_next));
endmodule

bind addimm_exec addimm_exec_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .ins_valid(ins_valid),
  .hdr(ins_word[DATA_W-1 -: 6+IDX_W]), .carry_in(carry_in),
  .wr_en(wr_en), .wr_idx(wr_idx), .carry_next(carry_next)
);

// File: tb/addimm_exec_bench.sv
module addimm_exec_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_word = '0;
  logic [31:0] src_val = '0;
  logic        carry_in = 1'b0;
  logic [4:0]  src_idx;
  logic        wr_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data;
  logic        carry_next;

  always #(CLK_PERIOD/2) clk = ~clk;

  addimm_exec u_addimm_exec (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_word(ins_word),
    .src_val(src_val), .carry_in(carry_in), .src_idx(src_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .carry_next(carry_next)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  bit          m_pend = 1'b0;
  logic [15:0] m_upper = '0;
  bit          m_c = 1'b0;

  function automatic logic [31:0] mk(logic [5:0] opc, logic [4:0] rd, logic [4:0] rs, logic [15:0] imm);
    return {opc, rd, rs, imm};
  endfunction

  function automatic logic [5:0] add_opc(bit k, bit c);
    return {3'b001, k, c, 1'b0};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // called at a negedge; returns at the following negedge
  task automatic step(bit v, logic [31:0] w, logic [31:0] s, bit c, string tag);
    bit          is_add, is_pfx, e_we, co;
    logic [31:0] op, e_sum;
    string       dtag, ctag;
    ins_valid = v; ins_word = w; src_val = s; carry_in = c;
    is_add = (w[31:29] == 3'b001) && !w[26];
    is_pfx = (w[31:26] == 6'b101100);
    e_we = 1'b0; e_sum = '0;
    dtag = tag; ctag = tag;
    if (v) begin
      if (is_add) begin
        op = m_pend ? {m_upper, w[15:0]} : {{16{w[15]}}, w[15:0]};
        {co, e_sum} = {1'b0, s} + {1'b0, op} + {32'd0, (w[27] & c)};
        e_we = 1'b1;
        m_c = w[28] ? c : co;
        if (tag == "") begin
          dtag = m_pend ? "R6" : (w[27] ? "R3" : "R2");
          ctag = w[28] ? "R5" : "R4";
        end
      end else begin
        m_c = c;
        if (tag == "") begin dtag = is_pfx ? "R6" : "R8"; ctag = dtag; end
      end
      m_pend = is_pfx;
      if (is_pfx) m_upper = w[15:0];
    end else if (tag == "") begin
      dtag = "R9"; ctag = "R9";
    end
    @(posedge clk);
    @(negedge clk);
    chk(wr_en == e_we, (e_we ? "R1" : dtag), "wr_en", {31'd0, wr_en}, {31'd0, e_we});
    if (e_we) begin
      chk(wr_idx == w[25:21], "R1", "wr_idx", {27'd0, wr_idx}, {27'd0, w[25:21]});
      chk(wr_data == e_sum, dtag, "wr_data", wr_data, e_sum);
    end
    chk(carry_next == m_c, ctag, "carry_next", {31'd0, carry_next}, {31'd0, m_c});
  endtask

  task automatic do_reset();
    rst = 1'b1; ins_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!wr_en, "R10", "wr_en in reset", {31'd0, wr_en}, 32'd0);
    chk(!carry_next, "R10", "carry in reset", {31'd0, carry_next}, 32'd0);
    rst = 1'b0;
    m_pend = 1'b0; m_c = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(posedge clk);
    @(negedge clk);
    do_reset();
    // R2 R4: -1 immediate with carry-out
    step(1, mk(add_opc(0,0), 5'd3, 5'd1, 16'hFFFF), 32'd5, 0, "");
    step(1, mk(add_opc(0,0), 5'd4, 5'd1, 16'h0001), 32'h7FFFFFFF, 0, "");
    // R3: carry-in alone overflows
    step(1, mk(add_opc(0,1), 5'd5, 5'd2, 16'h0000), 32'hFFFFFFFF, 1, "R3");
    // R3: C bit clear ignores a set flag
    step(1, mk(add_opc(0,0), 5'd6, 5'd2, 16'h0001), 32'd1, 1, "R3");
    // R5: overflow while keeping a clear flag
    step(1, mk(add_opc(1,0), 5'd7, 5'd2, 16'h0001), 32'hFFFFFFFF, 0, "R5");
    step(1, mk(add_opc(1,1), 5'd8, 5'd2, 16'h8000), 32'h00010000, 1, "R5");
    // R6: prefix then add
    step(1, mk(6'b101100, 5'd0, 5'd0, 16'h1234), 32'd0, 1, "R6");
    step(1, mk(add_opc(0,0), 5'd9, 5'd3, 16'h8000), 32'h00000010, 0, "R6");
    // R7: non-add word consumes the prefix
    step(1, mk(6'b101100, 5'd0, 5'd0, 16'hABCD), 32'd0, 0, "R7");
    step(1, mk(6'b010000, 5'd1, 5'd1, 16'h0000), 32'd0, 0, "R7");
    step(1, mk(add_opc(0,0), 5'd10, 5'd3, 16'h8000), 32'd0, 0, "R7");
    // R7: idle cycles keep it pending
    step(1, mk(6'b101100, 5'd0, 5'd0, 16'h00FF), 32'd0, 1, "R7");
    step(0, mk(add_opc(0,0), 5'd11, 5'd3, 16'h0001), 32'd0, 0, "R9");
    step(1, mk(add_opc(0,0), 5'd11, 5'd3, 16'hFFFF), 32'd1, 0, "R7");
    // R8: near-miss opcodes keep the incoming flag
    step(1, mk(6'b001001, 5'd12, 5'd3, 16'h0001), 32'd1, 1, "R8");
    step(1, mk(6'b101000, 5'd12, 5'd3, 16'h0001), 32'd1, 0, "R8");
    // R10: reset clears a pending prefix
    step(1, mk(6'b101100, 5'd0, 5'd0, 16'h7777), 32'd0, 1, "R10");
    do_reset();
    step(1, mk(add_opc(0,0), 5'd13, 5'd3, 16'hFFFE), 32'd3, 0, "R10");
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel;
      logic [5:0]  opc;
      logic [31:0] s;
      logic [15:0] imm;
      sel = $urandom % 8;
      case (sel)
        0, 1, 2, 3: opc = add_opc(sel[1], sel[0]);
        4:          opc = 6'b101100;
        5:          opc = 6'($urandom);
        6:          opc = {3'b001, 2'($urandom), 1'b1};
        default:    opc = add_opc(1'($urandom), 1'($urandom));
      endcase
      case ($urandom % 4)
        0:       s = 32'hFFFFFFFF;
        1:       s = 32'd0;
        default: s = $urandom;
      endcase
      imm = ($urandom % 5 == 0) ? 16'h8000 : 16'($urandom);
      step(($urandom % 10) != 0, mk(opc, 5'($urandom), 5'($urandom), imm), s, 1'($urandom), "");
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule